// File: doc/BRIEF.md
# Reset Cause Collector

This block combines four internal reset triggers into one stretched system reset. The triggers are a comparator that can be armed, a watchdog timeout strobe, an illegal flash access and a software-requested reset. It keeps a small status register that shows which trigger caused the most recent reset. That register is cleared only by power-on reset, so software can read it once the system comes back out of reset.

A flash access counts as illegal when either of these holds:
- The access reaches past the top of user code space, which ends at address 0x3DFF.
- The security logic refuses the access.

A separate reset-pin output follows only the power-on reset input. No internal trigger ever moves it.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `por_rst_n` is low, the block holds `reg_rd_data` at 0x00, `sys_rst_n` low and `pin_rst_n` low. After the first edge at which `por_rst_n` is sampled high, `pin_rst_n` is high. `sys_rst_n` stays low through the first 15 such edges and goes high on the 16th.
- R2: A trigger sampled on a rising edge drives `sys_rst_n` low from that edge onward. It stays low for exactly 16 cycles and goes high on the 16th edge after the trigger edge. A new trigger while `sys_rst_n` is low starts the 16-cycle count again.
- R3: A register write with data bit 4 set, made while `sys_rst_n` is high, causes a reset. Status bit 4 then reads 1.
- R4: A `wdt_timeout` strobe causes a reset. Status bit 3 then reads 1.
- R5: A write sets the comparator arm to data bit 5, so writing 1 arms it and writing 0 disarms it. The arm is kept across internal resets. While armed, a low `cmp_out` causes a reset on the third rising edge after it goes low, because of a two-flop synchronizer. Status bit 5 then reads 1. While disarmed, `cmp_out` has no effect.
- R6: With `fl_valid` high, an access of kind 2'b00 (code-space data read) or 2'b01 (instruction fetch) to an address above 0x3DFF is a flash error. The flash error causes a reset, and status bit 6 reads 1. An access to address 0x3DFF itself is not an error.
- R7: An access of kind 2'b10 (program-store write or erase) above 0x3DFF is an error only when `fl_wr_en` is high.
- R8: With `fl_valid` high, `fl_deny` is a flash error for every kind and every address, including kind 2'b11.
- R9: When several triggers fall in the same cycle, every one of their status bits is set.
- R10: Each new reset clears all earlier status bits and latches only the new causes. Without a trigger, the status is held, including across the stretched reset. `reg_rd_data` bits 7 and 2..0 always read 0.
- R11: No internal trigger ever drives `pin_rst_n` low.
- R12: Register writes made while `sys_rst_n` is low are ignored. They neither start a software reset nor change the comparator arm.
- R13: With `fl_valid` low, the flash inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, synchronous, active low |
| reg_wr_en | input | 1 | Write strobe for the status/control register |
| reg_wr_data | input | 8 | Write data (bit 5 arm, bit 4 software reset) |
| reg_rd_data | output | 8 | Status read (bits 6 flash, 5 comparator, 4 software, 3 watchdog) |
| cmp_out | input | 1 | Asynchronous comparator output, 0 requests reset when armed |
| wdt_timeout | input | 1 | Watchdog timeout strobe |
| fl_valid | input | 1 | Flash access qualifier |
| fl_kind | input | 2 | 00 code read, 01 fetch, 10 program write/erase, 11 other |
| fl_addr | input | 16 | Flash access address |
| fl_wr_en | input | 1 | Program-store write enable |
| fl_deny | input | 1 | Security logic refused the access |
| sys_rst_n | output | 1 | Stretched system reset, active low |
| pin_rst_n | output | 1 | External reset pin drive, follows power-on reset only |

## Verification
Two pairs of triggers are made to land on the same edge. First, a watchdog strobe and a software write. Second, a flash error and a watchdog strobe. In both cases the status must show every bit of the pair and only those bits. The random loop also draws a watchdog strobe next to each random flash access and random write, so mixed causes appear often. Each outcome is compared against a bench function that decides independently whether the access is illegal. A trigger that arrives while reset is already held is also provoked. It is judged by the remaining low time and by the fact that only its own bit remains in the status.

// File: rtl/rsc_pkg.sv
// Shared types and status bit positions for the reset cause collector.
// Assumes an 8-bit status register; bit positions are fixed software contract.
package rsc_pkg;
    typedef enum logic [1:0] {
        ACC_CODE_RD = 2'b00,
        ACC_FETCH   = 2'b01,
        ACC_PGM_WR  = 2'b10,
        ACC_OTHER   = 2'b11
    } acc_kind_e;

    localparam int REG_W    = 8;
    localparam int BIT_WDT  = 3;
    localparam int BIT_SW   = 4;
    localparam int BIT_CMP  = 5;
    localparam int BIT_FL   = 6;
endpackage

// File: rtl/rsc_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes the input is a slow level; RST_VAL is the idle (no request) value.
module rsc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rsc_flash_chk.sv
// Classifies one flash access as legal or illegal.
// Assumes fl_valid qualifies all other access inputs in the same cycle.
module rsc_flash_chk
    import rsc_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] USER_TOP = 16'h3DFF
) (
    input  logic              fl_valid,
    input  logic [1:0]        fl_kind,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic              fl_wr_en,
    input  logic              fl_deny,
    output logic              fl_err
);
    logic above_top;
    logic range_err;

    assign above_top = fl_addr > USER_TOP;

    // Decide whether the access kind is out of range for this address.
    always_comb begin
        unique case (acc_kind_e'(fl_kind))
            ACC_CODE_RD: range_err = above_top;
            ACC_FETCH:   range_err = above_top;
            ACC_PGM_WR:  range_err = above_top && fl_wr_en;
            default:     range_err = 1'b0;
        endcase
    end

    assign fl_err = fl_valid && (fl_deny || range_err);
endmodule

// File: rtl/rsc_stretch.sv
// Reset stretcher: holds the output low for CYCLES clocks after a trigger.
// Assumes a synchronous active-low power-on reset that also stretches.
module rsc_stretch #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic rst_out_n
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          out_q;

    // Load on trigger, count down, release when the count is spent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LOAD;
            out_q <= 1'b0;
        end else if (trig) begin
            cnt_q <= LOAD;
            out_q <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            out_q <= 1'b0;
        end else begin
            out_q <= 1'b1;
        end
    end

    assign rst_out_n = out_q;

    // R2
    trig_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !rst_out_n);
    // R2
    release_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out_n && !trig) |=> rst_out_n);
endmodule

// File: rtl/rst_cause_ctrl.sv
// Reset cause collector: merges comparator, watchdog, flash-error and
// software reset requests into one stretched system reset and records
// the causes of the latest reset in a status register kept until power-on.
// Assumes cmp_out is asynchronous; all other inputs are synchronous to clk.
module rst_cause_ctrl
    import rsc_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] USER_TOP = 16'h3DFF,
    parameter int              STRETCH  = 16,
    parameter int              SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              por_rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wr_data,
    output logic [REG_W-1:0]  reg_rd_data,
    input  logic              cmp_out,
    input  logic              wdt_timeout,
    input  logic              fl_valid,
    input  logic [1:0]        fl_kind,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic              fl_wr_en,
    input  logic              fl_deny,
    output logic              sys_rst_n,
    output logic              pin_rst_n
);
    localparam int NSRC = 4;
    localparam int IDX_WDT = 0;
    localparam int IDX_SW  = 1;
    localparam int IDX_CMP = 2;
    localparam int IDX_FL  = 3;

    logic            cmp_sync;
    logic            fl_err;
    logic            arm_q;
    logic            pin_q;
    logic            wr_ok;
    logic [NSRC-1:0] trig_vec;
    logic [NSRC-1:0] cause_q;
    logic            any_trig;

    rsc_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) i_cmp_sync (
        .clk     (clk),
        .rst_n   (por_rst_n),
        .d_async (cmp_out),
        .q_sync  (cmp_sync)
    );

    rsc_flash_chk #(.ADDR_W(ADDR_W), .USER_TOP(USER_TOP)) i_flash_chk (
        .fl_valid (fl_valid),
        .fl_kind  (fl_kind),
        .fl_addr  (fl_addr),
        .fl_wr_en (fl_wr_en),
        .fl_deny  (fl_deny),
        .fl_err   (fl_err)
    );

    rsc_stretch #(.CYCLES(STRETCH)) i_stretch (
        .clk       (clk),
        .rst_n     (por_rst_n),
        .trig      (any_trig),
        .rst_out_n (sys_rst_n)
    );

    // Writes take effect only while the system is out of reset.
    assign wr_ok = reg_wr_en && sys_rst_n;

    // Gather the per-source requests of this cycle.
    always_comb begin
        trig_vec          = '0;
        trig_vec[IDX_WDT] = wdt_timeout;
        trig_vec[IDX_SW]  = wr_ok && reg_wr_data[BIT_SW];
        trig_vec[IDX_CMP] = arm_q && !cmp_sync;
        trig_vec[IDX_FL]  = fl_err;
    end

    assign any_trig = |trig_vec;

    // Comparator arm follows bit 5 of each accepted write.
    always_ff @(posedge clk) begin
        if (!por_rst_n)  arm_q <= 1'b0;
        else if (wr_ok)  arm_q <= reg_wr_data[BIT_CMP];
    end

    // Replace the recorded causes whenever a new reset starts.
    always_ff @(posedge clk) begin
        if (!por_rst_n)    cause_q <= '0;
        else if (any_trig) cause_q <= trig_vec;
    end

    // Reset pin drive follows power-on reset alone.
    always_ff @(posedge clk) begin
        if (!por_rst_n) pin_q <= 1'b0;
        else            pin_q <= 1'b1;
    end

    assign pin_rst_n = pin_q;

    // Place recorded causes at their fixed status positions.
    always_comb begin
        reg_rd_data          = '0;
        reg_rd_data[BIT_WDT] = cause_q[IDX_WDT];
        reg_rd_data[BIT_SW]  = cause_q[IDX_SW];
        reg_rd_data[BIT_CMP] = cause_q[IDX_CMP];
        reg_rd_data[BIT_FL]  = cause_q[IDX_FL];
    end

    // R9
    multi_cause_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        (wdt_timeout && fl_err) |=> (reg_rd_data[BIT_WDT] && reg_rd_data[BIT_FL]));
    // R6
    flash_flag_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        fl_err |=> (reg_rd_data[BIT_FL] && !sys_rst_n));
    // R10
    status_hold_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        !any_trig |=> $stable(reg_rd_data));
    // R11
    pin_untouched_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        any_trig |=> pin_rst_n);
    // R12
    write_in_reset_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        (!sys_rst_n && reg_wr_en) |=> $stable(arm_q));
endmodule

// File: tb/test_rst_cause_ctrl.sv
`timescale 1ns/1ps
module test_rst_cause_ctrl;
    logic        clk = 1'b0;
    logic        por_rst_n;
    logic        reg_wr_en;
    logic [7:0]  reg_wr_data;
    logic [7:0]  reg_rd_data;
    logic        cmp_out;
    logic        wdt_timeout;
    logic        fl_valid;
    logic [1:0]  fl_kind;
    logic [15:0] fl_addr;
    logic        fl_wr_en;
    logic        fl_deny;
    logic        sys_rst_n;
    logic        pin_rst_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] exp_flags = 8'h00;

    always #2 clk = ~clk;

    rst_cause_ctrl i_rst_cause_ctrl (
        .clk(clk), .por_rst_n(por_rst_n), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .cmp_out(cmp_out), .wdt_timeout(wdt_timeout), .fl_valid(fl_valid),
        .fl_kind(fl_kind), .fl_addr(fl_addr), .fl_wr_en(fl_wr_en),
        .fl_deny(fl_deny), .sys_rst_n(sys_rst_n), .pin_rst_n(pin_rst_n)
    );

    function automatic bit exp_fl_err(bit v, logic [1:0] k, logic [15:0] a, bit we, bit dn);
        bit hi = (a > 16'h3DFF);
        if (!v) return 0;
        if (dn) return 1;
        if (k == 2'b00 || k == 2'b01) return hi;
        if (k == 2'b10) return hi && we;
        return 0;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr_en = 0; reg_wr_data = 0; wdt_timeout = 0;
        fl_valid = 0; fl_kind = 0; fl_addr = 0; fl_wr_en = 0; fl_deny = 0;
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!sys_rst_n && n < 200) begin n++; @(negedge clk); end
    endtask

    // One cycle of stimulus, then judge the outcome against the expectation.
    task automatic trial(bit wdt, bit wr, logic [7:0] wd, bit v, logic [1:0] k,
                         logic [15:0] a, bit we, bit dn, string req);
        logic [7:0] nf = 8'h00;
        int n;
        wdt_timeout = wdt; reg_wr_en = wr; reg_wr_data = wd;
        fl_valid = v; fl_kind = k; fl_addr = a; fl_wr_en = we; fl_deny = dn;
        if (wdt) nf[3] = 1;
        if (wr && wd[4]) nf[4] = 1;
        if (exp_fl_err(v, k, a, we, dn)) nf[6] = 1;
        @(negedge clk);
        idle();
        if (nf != 0) begin
            exp_flags = nf;
            chk(!sys_rst_n, req, "reset asserted", sys_rst_n, 0);
            chk(reg_rd_data == exp_flags, req, "status", reg_rd_data, exp_flags);
            count_low(n);
            chk(n == 16, "R2", "stretch length", n, 16);
        end else begin
            chk(sys_rst_n, req, "no reset", sys_rst_n, 1);
            chk(reg_rd_data == exp_flags, req, "status held", reg_rd_data, exp_flags);
        end
        chk(pin_rst_n, "R11", "pin stays high", pin_rst_n, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        idle(); cmp_out = 1; por_rst_n = 0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(reg_rd_data == 0, "R1", "status in POR", reg_rd_data, 0);
        chk(!sys_rst_n, "R1", "sys in POR", sys_rst_n, 0);
        chk(!pin_rst_n, "R1", "pin in POR", pin_rst_n, 0);
        por_rst_n = 1;
        @(negedge clk);
        chk(pin_rst_n, "R1", "pin after POR", pin_rst_n, 1);
        count_low(n);
        chk(n == 15, "R1", "POR stretch", n, 15);

        // R3, R4, R6, R7, R8, R13 directed
        trial(0, 1, 8'h10, 0, 0, 0, 0, 0, "R3");
        trial(1, 0, 0, 0, 0, 0, 0, 0, "R4");
        trial(0, 0, 0, 1, 2'b01, 16'h3DFF, 0, 0, "R6");
        trial(0, 0, 0, 1, 2'b01, 16'h3E00, 0, 0, "R6");
        trial(0, 0, 0, 1, 2'b00, 16'hFFFF, 0, 0, "R6");
        trial(0, 0, 0, 1, 2'b10, 16'h4000, 0, 0, "R7");
        trial(0, 0, 0, 1, 2'b10, 16'h4000, 1, 0, "R7");
        trial(0, 0, 0, 1, 2'b11, 16'h0000, 0, 1, "R8");
        trial(0, 0, 0, 0, 2'b01, 16'hF000, 1, 1, "R13");
        // R9 simultaneous causes
        trial(1, 1, 8'h10, 0, 0, 0, 0, 0, "R9");
        trial(1, 0, 0, 1, 2'b00, 16'h8000, 0, 0, "R9");
        // R10 all bits outside causes read zero
        chk((reg_rd_data & 8'h87) == 0, "R10", "unused bits", reg_rd_data, 0);

        // R2 restart during stretch, R10 flags replaced
        wdt_timeout = 1; @(negedge clk); idle();
        repeat (5) @(negedge clk);
        fl_valid = 1; fl_kind = 2'b01; fl_addr = 16'h5000; @(negedge clk); idle();
        chk(reg_rd_data == 8'h40, "R10", "flags replaced", reg_rd_data, 8'h40);
        count_low(n);
        chk(n == 16, "R2", "restart stretch", n, 16);
        exp_flags = 8'h40;

        // R12 write during reset is ignored
        wdt_timeout = 1; @(negedge clk); idle();
        reg_wr_en = 1; reg_wr_data = 8'h30; @(negedge clk); idle();
        count_low(n);
        chk(n == 15, "R12", "no software restart", n, 15);
        chk(reg_rd_data == 8'h08, "R12", "status", reg_rd_data, 8'h08);
        cmp_out = 0; repeat (5) @(negedge clk);
        chk(sys_rst_n, "R12", "arm not set", sys_rst_n, 1);
        cmp_out = 1; repeat (3) @(negedge clk);
        exp_flags = 8'h08;

        // R5 comparator arm, sync latency, flag
        trial(0, 1, 8'h20, 0, 0, 0, 0, 0, "R5");
        cmp_out = 0;
        @(negedge clk); chk(sys_rst_n, "R5", "edge 1", sys_rst_n, 1);
        @(negedge clk); chk(sys_rst_n, "R5", "edge 2", sys_rst_n, 1);
        @(negedge clk); chk(!sys_rst_n, "R5", "edge 3", sys_rst_n, 0);
        cmp_out = 1;
        count_low(n);
        chk(reg_rd_data == 8'h20, "R5", "comparator flag", reg_rd_data, 8'h20);
        exp_flags = 8'h20;
        trial(0, 1, 8'h00, 0, 0, 0, 0, 0, "R5");
        cmp_out = 0; repeat (6) @(negedge clk);
        chk(sys_rst_n, "R5", "disarmed", sys_rst_n, 1);
        cmp_out = 1; repeat (3) @(negedge clk);

        // Random mix of flash accesses, watchdog strobes and writes
        for (int i = 0; i < 80; i++) begin
            logic [15:0] a;
            logic [7:0]  wd;
            bit wr;
            if ($urandom_range(1, 0) == 1) a = 16'h3DFD + 16'($urandom_range(4, 0));
            else a = 16'($urandom);
            wr = ($urandom_range(3, 0) == 0);
            wd = 8'($urandom) & 8'hDF;
            trial($urandom_range(7, 0) == 0, wr, wd, $urandom_range(1, 0) == 1,
                  2'($urandom), a, $urandom_range(1, 0) == 1,
                  $urandom_range(9, 0) == 0, "R6");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule